// File: doc/BRIEF.md
# External Memory Bus Controller

This block connects the external-data move port of a small microcontroller core to two targets: an on-chip XRAM and an off-chip memory bus. A control register selects one of four steering modes. The modes are on-chip only, split without bank select, split with bank select, and off-chip only. The register also chooses between shared address/data pins and separate address and data pins. In shared-pin style, the low address byte is presented on the data pins. An address latch enable (ALE) pulse marks it, and the pulse high and low times are programmable.

The core issues a request in either 16-bit address form or 8-bit address form, plus a read/write flag and write data. An 8-bit request takes its upper address byte from one of two places. In split mode without bank select, it comes from the upper-address port latch. In every other mode, it comes from the page register. On-chip requests finish in one cycle with no stall. Off-chip requests raise `busy` until the bus cycle ends, and `done` then pulses for one cycle.

Top module: `emif_ctrl`

## Requirements
- R1: The control register resets to 0x03. Readback is {3'b000, field[4:0]}, so bits 7:5 always read 0 whatever is written. A write of 0xFF reads back 0x1F.
- R2: Mode field bits 3:2 = 00 (on-chip only): every access goes on-chip. The address is reduced modulo RAM_SIZE, and no external strobe or ALE is produced.
- R3: Mode 11 (off-chip only): every access runs an external bus cycle and `ram_en` never asserts.
- R4: Modes 01 and 10: a full address below RAM_SIZE goes on-chip. An address at or above RAM_SIZE goes off-chip. RAM_SIZE is a power of two, 2048 by default.
- R5: In mode 01, an 8-bit request uses the port latch `port_hi` as the upper address byte.
- R6: In modes 00, 10 and 11, an 8-bit request uses `page_hi` as the upper address byte. A 16-bit request always uses its own full address and ignores both `page_hi` and `port_hi`.
- R7: Bit 4 = 0 (shared pins): an off-chip cycle first holds `ext_ale` high for N+1 cycles, then low for N+1 cycles before the strobe. N is field bits 1:0. During both phases `ext_ad_o` carries the low address byte with `ext_ad_oe` high.
- R8: Bit 4 = 1 (separate pins): no ALE pulse is produced, whatever bits 1:0 hold, and the strobe starts in the first busy cycle.
- R9: The strobe lasts STROBE_CYC cycles and `ext_addr` carries the full address throughout. A read asserts only `ext_rd_n` low. A write asserts only `ext_wr_n` low and drives the write data with `ext_ad_oe` high.
- R10: `busy` is high from the cycle after an off-chip request until its last strobe cycle. In the cycle after that, `done` is high for one cycle with `rdata` holding `ext_ad_i` from a read. An on-chip request drives the RAM strobes in the request cycle and raises `done` with `rdata = ram_rdata` in the next cycle, without `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register readback |
| page_hi | input | 8 | Page register (bank-select upper byte) |
| port_hi | input | 8 | Upper-address port latch value |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_short | input | 1 | 1 = 8-bit address form |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address (bits 7:0 only in 8-bit form) |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Off-chip cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with done |
| ram_en | output | 1 | On-chip RAM access enable |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | AW | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data (combinational) |
| ext_addr | output | 16 | External address pins |
| ext_ad_o | output | 8 | External data pins (address/data out) |
| ext_ad_oe | output | 1 | Output enable for ext_ad_o |
| ext_ad_i | input | 8 | External data pins input |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |

## Verification
The on-chip RAM strobes follow the request in the same cycle. The bench therefore checks them one time step after driving the request on the falling edge, and checks `done` and `rdata` at the next falling edge.

For an off-chip request, every later falling edge is classed by the pins. A cycle counts as ALE high, ALE low with no strobe, or strobe, and the bench records the address and data pins in each phase. The counts must be 2(N+1) plus STROBE_CYC in shared-pin style, or STROBE_CYC alone in separate-pin style. The run of busy cycles must end in exactly one cycle with `done` high, and `rdata` is compared there.

// File: rtl/emif_pkg.sv
package emif_pkg;
    localparam logic [1:0] MODE_ONCHIP = 2'b00;
    localparam logic [1:0] MODE_SPLIT  = 2'b01;
    localparam logic [1:0] MODE_BANK   = 2'b10;
    localparam logic [1:0] MODE_OFFCHIP = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALE_HI,
        ST_ALE_LO,
        ST_STROBE
    } emif_state_e;

    typedef struct packed {
        logic       mux_n;
        logic [1:0] mode;
        logic [1:0] ale_len;
    } emif_cfg_t;
endpackage

// File: rtl/emif_cfg_reg.sv
module emif_cfg_reg
    import emif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output emif_cfg_t  cfg,
    output logic [7:0] rdata
);
    emif_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.mux_n   = wdata[4];
            cfg_d.mode    = wdata[3:2];
            cfg_d.ale_len = wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{mux_n: 1'b0, mode: MODE_ONCHIP, ale_len: 2'b11};
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign rdata = {3'b000, cfg_q.mux_n, cfg_q.mode, cfg_q.ale_len};
endmodule

// File: rtl/emif_steer.sv
module emif_steer
    import emif_pkg::*;
#(
    parameter int RAM_SIZE = 2048,
    localparam int AW = $clog2(RAM_SIZE)
) (
    input  logic [1:0]    mode,
    input  logic          short_form,
    input  logic [15:0]   addr_in,
    input  logic [7:0]    page_hi,
    input  logic [7:0]    port_hi,
    output logic [15:0]   full_addr,
    output logic          onchip,
    output logic [AW-1:0] ram_addr
);
    logic [7:0] hi_byte;

    always_comb begin
        if (!short_form)              hi_byte = addr_in[15:8];
        else if (mode == MODE_SPLIT)  hi_byte = port_hi;
        else                          hi_byte = page_hi;
        full_addr = {hi_byte, addr_in[7:0]};
        case (mode)
            MODE_ONCHIP:  onchip = 1'b1;
            MODE_OFFCHIP: onchip = 1'b0;
            default:      onchip = ({16'd0, full_addr} < 32'(RAM_SIZE));
        endcase
        ram_addr = full_addr[AW-1:0];
    end
endmodule

// File: rtl/emif_seq.sv
module emif_seq
    import emif_pkg::*;
#(
    parameter int STROBE_CYC = 2,
    localparam int CW = $clog2(STROBE_CYC + 4) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_on,
    input  logic        start_off,
    input  logic        start_mux_n,
    input  logic [1:0]  start_ale_len,
    input  logic        start_write,
    input  logic [15:0] start_addr,
    input  logic [7:0]  start_wdata,
    input  logic [7:0]  ram_rdata,
    input  logic [7:0]  ext_ad_i,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rdata,
    output logic [15:0] ext_addr,
    output logic [7:0]  ext_ad_o,
    output logic        ext_ad_oe,
    output logic        ext_ale,
    output logic        ext_rd_n,
    output logic        ext_wr_n
);
    localparam logic [CW-1:0] STROBE_LAST = CW'(STROBE_CYC - 1);

    typedef struct packed {
        emif_state_e state;
        logic [CW-1:0] cnt;
        logic [1:0]  ale_len;
        logic        write;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  rdata;
        logic        done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (start_on) begin
                    s_d.done  = 1'b1;
                    s_d.rdata = ram_rdata;
                end else if (start_off) begin
                    s_d.addr    = start_addr;
                    s_d.write   = start_write;
                    s_d.wdata   = start_wdata;
                    s_d.ale_len = start_ale_len;
                    if (start_mux_n) begin
                        s_d.state = ST_STROBE;
                        s_d.cnt   = STROBE_LAST;
                    end else begin
                        s_d.state = ST_ALE_HI;
                        s_d.cnt   = CW'(start_ale_len);
                    end
                end
            end
            ST_ALE_HI: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_ALE_LO;
                    s_d.cnt   = CW'(s_q.ale_len);
                end else s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_ALE_LO: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_STROBE;
                    s_d.cnt   = STROBE_LAST;
                end else s_d.cnt = s_q.cnt - 1'b1;
            end
            default: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                    if (!s_q.write) s_d.rdata = ext_ad_i;
                end else s_d.cnt = s_q.cnt - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy      = (s_q.state != ST_IDLE);
    assign done      = s_q.done;
    assign rdata     = s_q.rdata;
    assign ext_addr  = s_q.addr;
    assign ext_ale   = (s_q.state == ST_ALE_HI);
    assign ext_rd_n  = !((s_q.state == ST_STROBE) && !s_q.write);
    assign ext_wr_n  = !((s_q.state == ST_STROBE) && s_q.write);
    assign ext_ad_o  = (s_q.state == ST_STROBE) ? s_q.wdata : s_q.addr[7:0];
    assign ext_ad_oe = (s_q.state == ST_ALE_HI) || (s_q.state == ST_ALE_LO)
                     || ((s_q.state == ST_STROBE) && s_q.write);
endmodule

// File: rtl/emif_ctrl.sv
module emif_ctrl
    import emif_pkg::*;
#(
    parameter int RAM_SIZE   = 2048,
    parameter int STROBE_CYC = 2,
    localparam int AW = $clog2(RAM_SIZE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic [7:0]    page_hi,
    input  logic [7:0]    port_hi,
    input  logic          req_valid,
    input  logic          req_short,
    input  logic          req_write,
    input  logic [15:0]   req_addr,
    input  logic [7:0]    req_wdata,
    output logic          busy,
    output logic          done,
    output logic [7:0]    rdata,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    input  logic [7:0]    ram_rdata,
    output logic [15:0]   ext_addr,
    output logic [7:0]    ext_ad_o,
    output logic          ext_ad_oe,
    input  logic [7:0]    ext_ad_i,
    output logic          ext_ale,
    output logic          ext_rd_n,
    output logic          ext_wr_n
);
    emif_cfg_t     cfg;
    logic [15:0]   full_addr;
    logic          onchip;
    logic [AW-1:0] steer_ram_addr;
    logic          accept;

    emif_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    emif_steer #(.RAM_SIZE(RAM_SIZE)) u_steer (
        .mode       (cfg.mode),
        .short_form (req_short),
        .addr_in    (req_addr),
        .page_hi    (page_hi),
        .port_hi    (port_hi),
        .full_addr  (full_addr),
        .onchip     (onchip),
        .ram_addr   (steer_ram_addr)
    );

    assign accept    = req_valid && !busy;
    assign ram_en    = accept && onchip;
    assign ram_we    = accept && onchip && req_write;
    assign ram_addr  = steer_ram_addr;
    assign ram_wdata = req_wdata;

    emif_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_on      (accept && onchip),
        .start_off     (accept && !onchip),
        .start_mux_n   (cfg.mux_n),
        .start_ale_len (cfg.ale_len),
        .start_write   (req_write),
        .start_addr    (full_addr),
        .start_wdata   (req_wdata),
        .ram_rdata     (ram_rdata),
        .ext_ad_i      (ext_ad_i),
        .busy          (busy),
        .done          (done),
        .rdata         (rdata),
        .ext_addr      (ext_addr),
        .ext_ad_o      (ext_ad_o),
        .ext_ad_oe     (ext_ad_oe),
        .ext_ale       (ext_ale),
        .ext_rd_n      (ext_rd_n),
        .ext_wr_n      (ext_wr_n)
    );
endmodule

// File: rtl/emif_ctrl_chk.sv
module emif_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       busy,
    input logic       done,
    input logic       ram_en,
    input logic       ext_ale,
    input logic       ext_rd_n,
    input logic       ext_wr_n
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n)); // R9
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> busy); // R10
    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ale |-> (ext_rd_n && ext_wr_n && busy)); // R7
    AST_RAM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> !busy); // R10
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R10
    AST_OFFCHIP_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[3:2] == 2'b11) |-> !ram_en); // R3
endmodule

bind emif_ctrl emif_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .busy      (busy),
    .done      (done),
    .ram_en    (ram_en),
    .ext_ale   (ext_ale),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n)
);

// File: tb/sim_emif_ctrl.sv
`timescale 1ns/1ps
module sim_emif_ctrl;
    localparam int RAM_SIZE   = 2048;
    localparam int STROBE_CYC = 2;
    localparam int AW = $clog2(RAM_SIZE);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [7:0] page_hi = '0, port_hi = '0;
    logic req_valid = 1'b0, req_short = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic busy, done;
    logic [7:0] rdata;
    logic ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0] ram_wdata, ram_rdata;
    logic [15:0] ext_addr;
    logic [7:0] ext_ad_o, ext_ad_i = '0;
    logic ext_ad_oe, ext_ale, ext_rd_n, ext_wr_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    assign ram_rdata = ram_addr[7:0] ^ 8'h5A;

    emif_ctrl #(.RAM_SIZE(RAM_SIZE), .STROBE_CYC(STROBE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .page_hi(page_hi), .port_hi(port_hi),
        .req_valid(req_valid), .req_short(req_short), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ext_addr(ext_addr),
        .ext_ad_o(ext_ad_o), .ext_ad_oe(ext_ad_oe), .ext_ad_i(ext_ad_i),
        .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input logic [1:0] mode, input logic sh,
                                             input logic [15:0] a, input logic [7:0] pg,
                                             input logic [7:0] pt);
        logic [7:0] hi;
        if (!sh)              hi = a[15:8];
        else if (mode == 2'b01) hi = pt;
        else                  hi = pg;
        return {hi, a[7:0]};
    endfunction

    function automatic logic exp_on(input logic [1:0] mode, input logic [15:0] fa);
        if (mode == 2'b00) return 1'b1;
        if (mode == 2'b11) return 1'b0;
        return (32'(fa) < RAM_SIZE);
    endfunction

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic sh, input logic wr, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] xin);
        logic [1:0] mode;
        logic mux_n;
        int ale_n;
        logic [15:0] fa;
        logic on;
        int hi_c, lo_c, st_c, guard;
        logic addr_ok, ad_ok, strobe_ok;
        mode  = cfg_rdata[3:2];
        mux_n = cfg_rdata[4];
        ale_n = int'(cfg_rdata[1:0]) + 1;
        fa = exp_addr(mode, sh, a, page_hi, port_hi);
        on = exp_on(mode, fa);
        @(negedge clk);
        req_valid = 1'b1; req_short = sh; req_write = wr; req_addr = a;
        req_wdata = wd; ext_ad_i = xin;
        #1;
        check(on ? "R2/R4 on-chip steer" : "R3/R4 off-chip steer", 32'(ram_en), 32'(on));
        if (on) begin
            check("R2/R5/R6 ram_addr", 32'(ram_addr), 32'(fa[AW-1:0]));
            check("R10 ram_we", 32'(ram_we), 32'(wr));
            @(negedge clk);
            req_valid = 1'b0;
            check("R10 on-chip done", {30'd0, done, busy}, 32'd2);
            if (!wr) check("R10 on-chip rdata", 32'(rdata), 32'(fa[7:0] ^ 8'h5A));
            check("R2 no ext strobe", {29'd0, ext_ale, ext_rd_n, ext_wr_n}, 32'd3);
        end else begin
            @(negedge clk);
            req_valid = 1'b0;
            hi_c = 0; lo_c = 0; st_c = 0; guard = 0;
            addr_ok = 1'b1; ad_ok = 1'b1; strobe_ok = 1'b1;
            while (!done && guard < 100) begin
                guard++;
                if (busy) begin
                    if (ext_ale) begin
                        hi_c++;
                        if (ext_ad_o !== fa[7:0] || !ext_ad_oe) ad_ok = 1'b0;
                    end else if (ext_rd_n && ext_wr_n) begin
                        lo_c++;
                        if (ext_ad_o !== fa[7:0] || !ext_ad_oe || st_c != 0) ad_ok = 1'b0;
                    end else begin
                        st_c++;
                        if (ext_addr !== fa) addr_ok = 1'b0;
                        if (wr && (ext_wr_n || !ext_rd_n || !ext_ad_oe || ext_ad_o !== wd)) strobe_ok = 1'b0;
                        if (!wr && (ext_rd_n || !ext_wr_n)) strobe_ok = 1'b0;
                    end
                end
                @(negedge clk);
            end
            check("R10 done reached", 32'(done), 32'd1);
            check("R10 busy low at done", 32'(busy), 32'd0);
            check(mux_n ? "R8 no ALE" : "R7 ALE high cycles", 32'(hi_c), mux_n ? 32'd0 : 32'(ale_n));
            check(mux_n ? "R8 no ALE low phase" : "R7 ALE low cycles", 32'(lo_c), mux_n ? 32'd0 : 32'(ale_n));
            check("R7 low byte on AD", 32'(ad_ok), 32'd1);
            check("R9 strobe cycles", 32'(st_c), 32'(STROBE_CYC));
            check("R9/R5/R6 ext_addr", 32'(addr_ok), 32'd1);
            check("R9 strobe pins", 32'(strobe_ok), 32'd1);
            if (!wr) check("R10 ext rdata", 32'(rdata), 32'(xin));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", 32'(cfg_rdata), 32'h03);
        check("R10 reset idle", {29'd0, busy, done, ext_ale}, 32'd0);
        write_cfg(8'hFF);
        check("R1 unused bits read 0", 32'(cfg_rdata), 32'h1F);
        write_cfg(8'h03);
        page_hi = 8'h37; port_hi = 8'hC4;
        access(1'b0, 1'b0, 16'hF9AB, 8'h00, 8'h11);  // R2 alias
        access(1'b1, 1'b1, 16'h0012, 8'h66, 8'h00);  // R6 page in mode 00
        write_cfg(8'h05);                             // split, mux, ale 1 -> R4
        access(1'b0, 1'b0, 16'd2047, 8'h00, 8'h22);
        access(1'b0, 1'b0, 16'd2048, 8'h00, 8'h33);
        access(1'b1, 1'b1, 16'h0040, 8'h9C, 8'h00);  // R5 port latch
        write_cfg(8'h18);                             // bank, separate, ale 0 -> R8
        access(1'b1, 1'b0, 16'h0041, 8'h00, 8'hE1);  // R6 page
        access(1'b0, 1'b1, 16'h8123, 8'h7E, 8'h00);  // R6 16-bit ignores sources
        write_cfg(8'h1F);                             // R8 ALE field ignored
        access(1'b0, 1'b0, 16'h0003, 8'h00, 8'hB2);
        write_cfg(8'h0C);                             // R3 off-chip, mux, ale 0
        access(1'b0, 1'b0, 16'h0005, 8'h00, 8'h4D);
        for (int i = 0; i < 80; i++) begin
            logic [15:0] a;
            write_cfg(8'($urandom_range(0, 31)));
            page_hi = 8'($urandom); port_hi = 8'($urandom);
            a = 16'($urandom);
            if ($urandom_range(0, 2) == 0) a = 16'(RAM_SIZE - 2 + $urandom_range(0, 3));
            access(1'($urandom), 1'($urandom), a, 8'($urandom), 8'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule